// File: doc/BRIEF.md
# Accumulator Processor with Index Register

A compact multi-cycle processor core built around one 16-bit accumulator (AC), a 12-bit program counter (PC) and an 8-bit index register (IX). Instructions and data live in one word-addressed memory reached through a single synchronous port. Each instruction word carries an opcode in its upper four bits and an address field in its lower twelve bits.

Beyond plain accumulator arithmetic, the core can read or rewrite just the address field of a memory word. A program can therefore patch its own operand addresses inside a loop. It can also run counted loops through the index register, whose branch-if-zero instruction steps the register upward when it does not branch. The index value is sign-extended before it is added to an address, so a loop can count from a negative start up to zero. A halt instruction freezes the core and raises a status output. Only a reset restarts the core.

Instruction fetch and decode take two cycles. An instruction that reads a data operand takes one more cycle.

Top module: `acp_core`

## Requirements
- R1: While reset (active low) is asserted and in the first cycle after it is released, the core drives address 0, keeps the write strobe low and keeps halt low. Execution starts at word 0 with AC and IX both zero.
- R2: The opcode is held in instruction bits 15:12 and the field x in bits 11:0. The encodings are: 0 halt, 1 load, 2 store, 3 add, 4 sub, 5 jump, 6 jump-if-nonnegative, 7 load-field, 8 store-field, 9 indexed load, A indexed add, B index-branch, C load-index, D store-index, E index-increment, F no-op.
- R3: Load sets AC to M[x]. Store writes AC to M[x]. Add and sub set AC to AC+M[x] and AC-M[x], wrapping modulo 2^16.
- R4: Jump sets PC to x. Jump-if-nonnegative sets PC to x only when AC bit 15 is 0; otherwise execution continues with the next word.
- R5: Load-field sets AC to bits 11:0 of M[x], with the upper four bits of AC cleared.
- R6: Store-field replaces bits 11:0 of M[x] with AC bits 11:0 and leaves bits 15:12 of that word as they were.
- R7: Indexed load and indexed add use the address (x + sign-extended IX) modulo 4096 in place of x.
- R8: Index-branch sets PC to x when IX is zero. Otherwise it adds one to IX (modulo 256) and continues with the next word.
- R9: Load-index sets IX to bits 7:0 of M[x]. Store-index writes IX to M[x], sign-extended to 16 bits.
- R10: Index-increment adds bits 7:0 of x to IX modulo 256 and leaves AC unchanged.
- R11: Halt raises the halt output. The output stays high until reset and no further memory write occurs. The no-op only advances PC.
- R12: Read data is taken one cycle after its address is driven. A write strobe lasts exactly one cycle and is never asserted in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address for fetch, operand read or write |
| mem_wdata | output | 16 | Data to write |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
Hand-built programs target one behaviour each:
- a field load followed by a field store into a word with a distinctive opcode, which separates a field-only write from a full-word write;
- an index loop that starts at -3, which exposes a missing sign extension or an increment placed in the wrong order;
- a mixed program that checks a negative store-index and an AC left untouched by an index increment;
- a program that takes one arm of the sign branch and skips the other.

Randomly generated straight-line programs with forward branches mix every operation over random data. Their final data region is compared word by word against an instruction-level model in the bench, which catches errors in operand routing and wrapping that the directed cases never reach.

// File: rtl/acp_pkg.sv
package acp_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned OPC_W  = 4;
    localparam int unsigned IX_W   = 8;
    localparam int unsigned ADDR_W = WORD_W - OPC_W;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 4'h0,
        OP_LOAD  = 4'h1,
        OP_STORE = 4'h2,
        OP_ADD   = 4'h3,
        OP_SUB   = 4'h4,
        OP_JUMP  = 4'h5,
        OP_JGE   = 4'h6,
        OP_LDFLD = 4'h7,
        OP_STFLD = 4'h8,
        OP_LDX   = 4'h9,
        OP_ADDX  = 4'hA,
        OP_JZI   = 4'hB,
        OP_LDI   = 4'hC,
        OP_STI   = 4'hD,
        OP_INCI  = 4'hE,
        OP_NOP   = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_HALT   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   pc;
        logic [WORD_W-1:0]   ac;
        logic [IX_W-1:0]     ix;
        opcode_e             op;
        logic [ADDR_W-1:0]   ea;
    } core_st_t;

    typedef struct packed {
        logic rd_operand;
        logic use_ix;
    } ctl_t;
endpackage

// File: rtl/acp_decode.sv
module acp_decode
    import acp_pkg::*;
(
    input  opcode_e op,
    output ctl_t    ctl
);
    always_comb begin
        ctl = '0;
        case (op)
            OP_LOAD, OP_ADD, OP_SUB, OP_LDFLD, OP_STFLD, OP_LDI: ctl.rd_operand = 1'b1;
            OP_LDX, OP_ADDX: begin
                ctl.rd_operand = 1'b1;
                ctl.use_ix     = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/acp_agen.sv
module acp_agen
    import acp_pkg::*;
(
    input  logic [ADDR_W-1:0] field,
    input  logic [IX_W-1:0]   ix,
    input  logic              use_ix,
    output logic [ADDR_W-1:0] ea
);
    localparam int unsigned EXT_W = ADDR_W - IX_W;
    logic [ADDR_W-1:0] ix_ext;

    always_comb begin
        ix_ext = {{EXT_W{ix[IX_W-1]}}, ix};
        ea     = use_ix ? field + ix_ext : field;
    end
endmodule

// File: rtl/acp_alu.sv
module acp_alu
    import acp_pkg::*;
(
    input  opcode_e           op,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] operand,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        case (op)
            OP_LOAD, OP_LDX: result = operand;
            OP_ADD, OP_ADDX: result = ac + operand;
            OP_SUB:          result = ac - operand;
            OP_LDFLD:        result = {{OPC_W{1'b0}}, operand[ADDR_W-1:0]};
            default:         result = ac;
        endcase
    end
endmodule

// File: rtl/acp_core.sv
module acp_core
    import acp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [11:0]       mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              mem_we,
    input  logic [15:0]       mem_rdata,
    output logic              halted
);
    localparam int unsigned EXT_W = WORD_W - IX_W;

    core_st_t          st_q, st_d;
    opcode_e           instr_op;
    logic [ADDR_W-1:0] field;
    ctl_t              ctl;
    logic [ADDR_W-1:0] ea;
    logic [WORD_W-1:0] alu_res;

    assign instr_op = opcode_e'(mem_rdata[WORD_W-1:ADDR_W]);
    assign field    = mem_rdata[ADDR_W-1:0];

    acp_decode u_decode (
        .op  (instr_op),
        .ctl (ctl)
    );

    acp_agen u_agen (
        .field  (field),
        .ix     (st_q.ix),
        .use_ix (ctl.use_ix),
        .ea     (ea)
    );

    acp_alu u_alu (
        .op      (st_q.op),
        .ac      (st_q.ac),
        .operand (mem_rdata),
        .result  (alu_res)
    );

    always_comb begin
        st_d      = st_q;
        mem_addr  = st_q.pc;
        mem_wdata = '0;
        mem_we    = 1'b0;
        halted    = (st_q.phase == PH_HALT);
        case (st_q.phase)
            PH_FETCH: begin
                st_d.phase = PH_DECODE;
            end
            PH_DECODE: begin
                st_d.pc    = st_q.pc + 1'b1;
                st_d.op    = instr_op;
                st_d.ea    = ea;
                st_d.phase = PH_FETCH;
                if (ctl.rd_operand) begin
                    mem_addr   = ea;
                    st_d.phase = PH_EXEC;
                end else begin
                    case (instr_op)
                        OP_HALT: begin
                            st_d.pc    = st_q.pc;
                            st_d.phase = PH_HALT;
                        end
                        OP_STORE: begin
                            mem_addr  = field;
                            mem_wdata = st_q.ac;
                            mem_we    = 1'b1;
                        end
                        OP_STI: begin
                            mem_addr  = field;
                            mem_wdata = {{EXT_W{st_q.ix[IX_W-1]}}, st_q.ix};
                            mem_we    = 1'b1;
                        end
                        OP_JUMP: st_d.pc = field;
                        OP_JGE: begin
                            if (!st_q.ac[WORD_W-1]) st_d.pc = field;
                        end
                        OP_JZI: begin
                            if (st_q.ix == '0) st_d.pc = field;
                            else               st_d.ix = st_q.ix + 1'b1;
                        end
                        OP_INCI: st_d.ix = st_q.ix + field[IX_W-1:0];
                        default: st_d.phase = PH_FETCH;
                    endcase
                end
            end
            PH_EXEC: begin
                mem_addr   = st_q.ea;
                st_d.phase = PH_FETCH;
                st_d.ac    = alu_res;
                if (st_q.op == OP_STFLD) begin
                    mem_wdata = {mem_rdata[WORD_W-1:ADDR_W], st_q.ac[ADDR_W-1:0]};
                    mem_we    = 1'b1;
                end
                if (st_q.op == OP_LDI) st_d.ix = mem_rdata[IX_W-1:0];
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_FETCH;
            st_q.pc    <= '0;
            st_q.ac    <= '0;
            st_q.ix    <= '0;
            st_q.op    <= OP_NOP;
            st_q.ea    <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/acp_core_chk.sv
module acp_core_chk
    import acp_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        mem_we,
    input logic        halted,
    input phase_e      phase,
    input logic [11:0] pc,
    input logic [7:0]  ix,
    input logic [15:0] ac,
    input logic [15:0] rdata
);
    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R12
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && rdata[15:12] == OP_JUMP) |=> pc == $past(rdata[11:0]));

    // R8
    jzi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && rdata[15:12] == OP_JZI && ix != 8'd0) |=> ix == $past(ix) + 8'd1);

    // R10
    inci_keep_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && rdata[15:12] == OP_INCI) |=> $stable(ac));
endmodule

bind acp_core acp_core_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_we (mem_we),
    .halted (halted),
    .phase  (st_q.phase),
    .pc     (st_q.pc),
    .ix     (st_q.ix),
    .ac     (st_q.ac),
    .rdata  (mem_rdata)
);

// File: tb/acp_core_bench.sv
module acp_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] O_HALT = 4'h0, O_LOAD = 4'h1, O_STORE = 4'h2, O_ADD = 4'h3,
        O_SUB = 4'h4, O_JUMP = 4'h5, O_JGE = 4'h6, O_LDF = 4'h7, O_STF = 4'h8,
        O_LDX = 4'h9, O_ADDX = 4'hA, O_JZI = 4'hB, O_LDI = 4'hC, O_STI = 4'hD,
        O_INCI = 4'hE, O_NOP = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    logic [15:0] mem     [0:4095];
    logic [15:0] ref_mem [0:4095];

    int total = 0;
    int bad = 0;
    int we_pairs = 0;
    logic prev_we = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acp_core u_acp_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // R12 monitor: no two consecutive write cycles
    always @(negedge clk) begin
        if (rst_n && mem_we && prev_we) we_pairs++;
        prev_we <= rst_n & mem_we;
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] x);
        return {op, x};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] v);
        mem[a] = v;
        ref_mem[a] = v;
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 16'h0000;
            ref_mem[i] = 16'h0000;
        end
    endtask

    // instruction-level reference of the requirements
    task automatic ref_run();
        logic [15:0] ac = '0;
        logic [7:0]  ix = '0;
        logic [11:0] pc = '0;
        logic [15:0] w;
        logic [11:0] f, ea;
        bit stop = 0;
        int steps = 0;
        while (!stop && steps < 4000) begin
            w = ref_mem[pc];
            f = w[11:0];
            ea = f + {{4{ix[7]}}, ix};
            pc = pc + 12'd1;
            steps++;
            case (w[15:12])
                O_HALT:  stop = 1;
                O_LOAD:  ac = ref_mem[f];
                O_STORE: ref_mem[f] = ac;
                O_ADD:   ac = ac + ref_mem[f];
                O_SUB:   ac = ac - ref_mem[f];
                O_JUMP:  pc = f;
                O_JGE:   if (!ac[15]) pc = f;
                O_LDF:   ac = {4'h0, ref_mem[f][11:0]};
                O_STF:   ref_mem[f] = {ref_mem[f][15:12], ac[11:0]};
                O_LDX:   ac = ref_mem[ea];
                O_ADDX:  ac = ac + ref_mem[ea];
                O_JZI:   if (ix == 8'd0) pc = f; else ix = ix + 8'd1;
                O_LDI:   ix = ref_mem[f][7:0];
                O_STI:   ref_mem[f] = {{8{ix[7]}}, ix};
                O_INCI:  ix = ix + f[7:0];
                default: ;
            endcase
        end
    endtask

    task automatic run_dut(input string req);
        int n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " halt reached"}, {15'd0, halted}, 16'd1);
    endtask

    task automatic compare_region(input string req);
        int mism = 0;
        int first = -1;
        for (int a = 16'h100; a < 16'h200; a++) begin
            if (mem[a] !== ref_mem[a]) begin
                mism++;
                if (first < 0) first = a;
            end
        end
        total++;
        if (mism != 0) begin
            bad++;
            $display("FAIL %s word %h act=%h exp=%h", req, first[11:0], mem[first], ref_mem[first]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ok;
        int len;
        int sel;
        logic [3:0] op;
        logic [11:0] x;
        void'($urandom(32'h5A17));

        // R1 reset state
        begin_prog();
        put(16'h100, 16'hA123);
        put(16'h101, 16'h0001);
        put(16'h102, 16'h7FFF);
        // R2 encodings: 7 load-field, 3 add, 8 store-field, 0 halt
        put(0, ins(O_LDF, 12'h100));
        put(1, ins(O_ADD, 12'h101));
        put(2, ins(O_STF, 12'h102));
        put(3, ins(O_HALT, 12'h000));
        check("R1 reset addr", {4'h0, mem_addr}, 16'h0000);
        check("R1 reset we", {15'd0, mem_we}, 16'd0);
        check("R1 reset halt", {15'd0, halted}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 first fetch addr", {4'h0, mem_addr}, 16'h0000);
        check("R1 first fetch halt", {15'd0, halted}, 16'd0);
        begin
            int n = 0;
            while (!halted && n < 100) begin @(negedge clk); n++; end
        end
        // R5 field 0x123 + 1, R6 opcode 7 kept
        check("R6 store-field keeps opcode", mem[16'h102], 16'h7124);
        check("R5 load-field untouched source", mem[16'h100], 16'hA123);

        // R7 R8 index loop from -3
        begin_prog();
        put(16'h120, 16'hFFFD);
        put(16'h101, 16'd10);
        put(16'h102, 16'd20);
        put(16'h103, 16'd30);
        put(0, ins(O_LDI, 12'h120));
        put(1, ins(O_LOAD, 12'h121));
        put(2, ins(O_JZI, 12'h006));
        put(3, ins(O_ADDX, 12'h103));
        put(4, ins(O_JUMP, 12'h002));
        put(6, ins(O_STORE, 12'h130));
        put(7, ins(O_STI, 12'h131));
        put(8, ins(O_HALT, 12'h000));
        run_dut("R8");
        check("R7 indexed sum", mem[16'h130], 16'd60);
        check("R8 index ends at zero", mem[16'h131], 16'h0000);

        // R9 R10 R11
        begin_prog();
        put(16'h120, 16'h1285);
        put(16'h121, 16'h4444);
        put(0, ins(O_LDI, 12'h120));
        put(1, ins(O_LOAD, 12'h121));
        put(2, ins(O_INCI, 12'h003));
        put(3, ins(O_STI, 12'h132));
        put(4, ins(O_STORE, 12'h133));
        put(5, ins(O_NOP, 12'h000));
        put(6, ins(O_HALT, 12'h000));
        put(7, ins(O_STORE, 12'h134));
        run_dut("R11");
        check("R9 store-index sign extends", mem[16'h132], 16'hFF88);
        check("R10 AC kept by increment", mem[16'h133], 16'h4444);
        ok = 1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!halted || mem_we) ok = 0;
        end
        check("R11 halt held without writes", {15'd0, ok}, 16'd1);
        check("R11 nothing after halt", mem[16'h134], 16'h0000);

        // R4 R3 sign branch
        begin_prog();
        put(16'h120, 16'd5);
        put(16'h121, 16'd7);
        put(16'h135, 16'hDEAD);
        put(16'h136, 16'hDEAD);
        put(0, ins(O_LOAD, 12'h120));
        put(1, ins(O_SUB, 12'h121));
        put(2, ins(O_JGE, 12'h005));
        put(3, ins(O_STORE, 12'h134));
        put(4, ins(O_JUMP, 12'h006));
        put(5, ins(O_STORE, 12'h135));
        put(6, ins(O_LOAD, 12'h121));
        put(7, ins(O_JGE, 12'h009));
        put(8, ins(O_STORE, 12'h136));
        put(9, ins(O_HALT, 12'h000));
        run_dut("R4");
        check("R3 sub wraps negative", mem[16'h134], 16'hFFFE);
        check("R4 jump skips word", mem[16'h135], 16'hDEAD);
        check("R4 nonnegative branch taken", mem[16'h136], 16'hDEAD);

        // random programs: R3 R5 R6 R7 R8 R9 R10
        for (int p = 0; p < 24; p++) begin
            begin_prog();
            len = 12;
            for (int a = 16'h100; a < 16'h200; a++) put(a, 16'($urandom));
            for (int i = 0; i < len; i++) begin
                sel = $urandom % 15;
                op = 4'(sel + 1);
                case (op)
                    O_STORE, O_STF, O_STI: x = 12'h140 + 12'($urandom % 32);
                    O_LDX, O_ADDX:         x = 12'h180 + 12'($urandom % 32);
                    O_JUMP, O_JGE, O_JZI: begin
                        x = 12'(i + 1 + ($urandom % 3));
                        if (x > 12'(len)) x = 12'(len);
                    end
                    O_INCI:                x = 12'($urandom % 256);
                    default:               x = 12'h100 + 12'($urandom % 64);
                endcase
                put(i, ins(op, x));
            end
            put(len, ins(O_STORE, 12'h1F0));
            put(len + 1, ins(O_STI, 12'h1F1));
            put(len + 2, ins(O_HALT, 12'h000));
            ref_run();
            run_dut("R3 random");
            compare_region("R3 R5 R6 R7 R8 R9 R10 random program");
        end

        check("R12 no back-to-back writes", 16'(we_pairs), 16'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule